// File: doc/BRIEF.md
# Vector-Input Polyphase FIR Decimator

This block low-pass filters and decimates a sample stream that arrives as a vector of `V` signed samples per clock. A single output sample leaves for every `D` input samples, where the decimation factor `D` is an exact multiple of `V`. Each vector lane has its own multiply-accumulate datapath. Over the `D/V` cycles of a decimation frame, that datapath steps through the coefficients of the polyphase branches that fall on its lane, so one set of lane hardware covers the whole filter. The coefficients are fixed parameters. Arithmetic keeps full precision throughout.

The result matches a plain decimating FIR whose input has `D-1` zero samples placed in front of it. In other words, output `f` uses input sample `f*D + D-1` as its newest tap. The reset `rst_n` clears only the control state: the phase counter and the valid pipeline. The synchronous input `srst` also clears the delay lines, accumulators and output register. A user who does not need it ties it low.

Top module: `vec_fir_decim`

## Requirements
- R1: Once `rst_n` is released, `out_vld` stays low until a complete frame of valid vectors has been accepted.
- R2: Output `f` equals the sum over `j` from 0 to N-1 of `h[j]*x[f*D + D-1 - j]`, where `x[i]` is the i-th valid input sample and `x[i]=0` for `i<0`.
- R3: A phase counter runs from 0 to D/V-1 and advances only on accepted vectors. Exactly one output is produced per D/V valid input cycles.
- R4: When the vector that completes a frame is accepted at clock edge E, `out_vld` is high after edge E+2 (three register stages).
- R5: Lane k of `in_data`, at bits `[k*W +: W]`, holds the sample that is earlier in time than lane k+1. Lane 0 is the oldest.
- R6: A cycle with `in_vld` low leaves the phase, accumulators and delay lines unchanged, whatever `in_data` carries.
- R7: `out_data` is W+CW+clog2(N) bits wide, two's complement, with no rounding or saturation.
- R8: `srst` high at a clock edge clears the phase, the valid pipeline, the delay lines and the accumulators. The next frame starts from zero history.
- R9: `rst_n` does not clear the delay lines. After a reset taken at a frame boundary, the next output still includes samples from before the reset.
- R10: When D/V > 1, `out_vld` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| srst | input | 1 | Synchronous clear of control and data state |
| in_vld | input | 1 | Input vector valid |
| in_data | input | V*W | Input vector, lane k at bits [k*W +: W], lane 0 oldest |
| out_vld | output | 1 | Output sample valid |
| out_data | output | W+CW+clog2(N) | Decimated output, signed full precision |

## Verification
A vector that completes a frame is accepted at one edge. Its output is due at the third falling edge after the bench drives it: one register for the product, one for the lane total and one for the lane sum. The latency scenario samples `out_vld` on each of the four falling edges after that drive and expects it high only on the third. Every other scenario lets a falling-edge monitor record each valid output. Each scenario then waits several idle cycles before it compares the recorded outputs in order against a reference computed from the accepted sample stream. The checks therefore do not depend on the exact edge inside a long stream, while the output count and order are still checked.

// File: rtl/fir_dec_pkg.sv
package fir_dec_pkg;

    // Coefficient index used by lane `lane` for branch `r` at frame cycle `c`.
    function automatic int coef_index(input int r, input int dec, input int c,
                                      input int vec, input int lane);
        return r * dec + dec - 1 - c * vec - lane;
    endfunction

endpackage

// File: rtl/fir_dec_ctrl.sv
module fir_dec_ctrl #(
    parameter int DV  = 2,
    parameter int PCW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           srst,
    input  logic           in_vld,
    output logic [PCW-1:0] phase,
    output logic           s1_vld,
    output logic           s1_last,
    output logic           s2_done,
    output logic           out_vld
);
    localparam logic [PCW-1:0] LAST = PCW'(DV - 1);

    typedef struct packed {
        logic [PCW-1:0] phase;
        logic           s1_vld;
        logic           s1_last;
        logic           s2_done;
        logic           out_vld;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (srst) begin
            ctrl_d = '0;
        end else begin
            ctrl_d.s1_vld  = in_vld;
            ctrl_d.s1_last = in_vld && (ctrl_q.phase == LAST);
            ctrl_d.s2_done = ctrl_q.s1_vld && ctrl_q.s1_last;
            ctrl_d.out_vld = ctrl_q.s2_done;
            if (in_vld) begin
                ctrl_d.phase = (ctrl_q.phase == LAST) ? '0 : ctrl_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign phase   = ctrl_q.phase;
    assign s1_vld  = ctrl_q.s1_vld;
    assign s1_last = ctrl_q.s1_last;
    assign s2_done = ctrl_q.s2_done;
    assign out_vld = ctrl_q.out_vld;
endmodule

// File: rtl/fir_dec_lane.sv
module fir_dec_lane
    import fir_dec_pkg::*;
#(
    parameter int              W      = 16,
    parameter int              CW     = 16,
    parameter int              N      = 16,
    parameter int              D      = 8,
    parameter int              V      = 4,
    parameter int              LANE   = 0,
    parameter int              AW     = 36,
    parameter int              PCW    = 1,
    parameter logic [N*CW-1:0] COEFS  = '0
) (
    input  logic                 clk,
    input  logic                 srst,
    input  logic                 in_vld,
    input  logic signed [W-1:0]  sample,
    input  logic [PCW-1:0]       phase,
    input  logic                 s1_vld,
    input  logic                 s1_last,
    output logic signed [AW-1:0] tot
);
    localparam int DV = D / V;
    localparam int R  = (N + D - 1) / D;
    localparam int HL = ((R - 1) * DV > 0) ? (R - 1) * DV : 1;

    typedef struct packed {
        logic [HL-1:0][W-1:0] line;
        logic signed [AW-1:0] prod;
        logic signed [AW-1:0] acc;
        logic signed [AW-1:0] tot;
    } lane_t;

    lane_t lane_d, lane_q;
    logic signed [AW-1:0] psum;

    // Products of this lane for the current frame cycle, all branches summed.
    always_comb begin
        psum = '0;
        for (int r = 0; r < R; r++) begin
            int idx;
            logic signed [W-1:0]  tap;
            logic signed [CW-1:0] cf;
            idx = coef_index(r, D, int'(phase), V, LANE);
            tap = (r == 0) ? sample : $signed(lane_q.line[(r == 0) ? 0 : r * DV - 1]);
            cf  = (idx < N) ? $signed(COEFS[idx*CW +: CW]) : '0;
            psum = psum + AW'(cf) * AW'(tap);
        end
    end

    always_comb begin
        lane_d = lane_q;
        if (srst) begin
            lane_d = '0;
        end else begin
            if (in_vld) begin
                lane_d.line[0] = sample;
                for (int i = 1; i < HL; i++) lane_d.line[i] = lane_q.line[i-1];
                lane_d.prod = psum;
            end
            if (s1_vld) begin
                if (s1_last) begin
                    lane_d.tot = lane_q.acc + lane_q.prod;
                    lane_d.acc = '0;
                end else begin
                    lane_d.acc = lane_q.acc + lane_q.prod;
                end
            end
        end
    end

    always_ff @(posedge clk) lane_q <= lane_d;

    assign tot = lane_q.tot;
endmodule

// File: rtl/fir_dec_sum.sv
module fir_dec_sum #(
    parameter int V  = 4,
    parameter int AW = 36
) (
    input  logic                 clk,
    input  logic                 srst,
    input  logic                 s2_done,
    input  logic [V*AW-1:0]      tots,
    output logic signed [AW-1:0] out_data
);
    logic signed [AW-1:0] out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (srst) begin
            out_d = '0;
        end else if (s2_done) begin
            out_d = '0;
            for (int k = 0; k < V; k++) out_d = out_d + $signed(tots[k*AW +: AW]);
        end
    end

    always_ff @(posedge clk) out_q <= out_d;

    assign out_data = out_q;
endmodule

// File: rtl/vec_fir_decim.sv
module vec_fir_decim #(
    parameter int              W     = 16,
    parameter int              CW    = 16,
    parameter int              N     = 16,
    parameter int              V     = 4,
    parameter int              D     = 8,
    parameter logic [N*CW-1:0] COEFS = {
        -16'sd4,  16'sd8,  16'sd3, -16'sd7,  16'sd5, -16'sd2,  16'sd1,  16'sd6,
        -16'sd8,  16'sd4,  16'sd9, -16'sd1,  16'sd2,  16'sd7, -16'sd5,  16'sd3}
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 srst,
    input  logic                                 in_vld,
    input  logic [V*W-1:0]                       in_data,
    output logic                                 out_vld,
    output logic signed [W+CW+$clog2(N)-1:0]     out_data
);
    localparam int DV  = D / V;
    localparam int AW  = W + CW + $clog2(N);
    localparam int PCW = (DV > 1) ? $clog2(DV) : 1;

    if (D % V != 0) begin : g_bad_ratio
        $error("decimation factor must be a multiple of the vector size");
    end

    logic [PCW-1:0]  phase;
    logic            s1_vld, s1_last, s2_done;
    logic [V*AW-1:0] tots;

    fir_dec_ctrl #(.DV(DV), .PCW(PCW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .srst(srst), .in_vld(in_vld),
        .phase(phase), .s1_vld(s1_vld), .s1_last(s1_last),
        .s2_done(s2_done), .out_vld(out_vld)
    );

    for (genvar k = 0; k < V; k++) begin : g_lane
        logic signed [AW-1:0] lane_tot;
        fir_dec_lane #(
            .W(W), .CW(CW), .N(N), .D(D), .V(V), .LANE(k),
            .AW(AW), .PCW(PCW), .COEFS(COEFS)
        ) u_lane (
            .clk(clk), .srst(srst), .in_vld(in_vld),
            .sample($signed(in_data[k*W +: W])), .phase(phase),
            .s1_vld(s1_vld), .s1_last(s1_last), .tot(lane_tot)
        );
        assign tots[k*AW +: AW] = lane_tot;
    end

    fir_dec_sum #(.V(V), .AW(AW)) u_sum (
        .clk(clk), .srst(srst), .s2_done(s2_done),
        .tots(tots), .out_data(out_data)
    );
endmodule

// File: rtl/vec_fir_decim_chk.sv
module vec_fir_decim_chk #(
    parameter int DV  = 2,
    parameter int PCW = 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           srst,
    input logic           in_vld,
    input logic [PCW-1:0] phase,
    input logic           out_vld
);
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase) < DV); // R3

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && !srst) |=> $stable(phase)); // R6

    AST_FRAME_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($past(in_vld, 3) && int'($past(phase, 3)) == DV - 1)); // R4

    AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!out_vld && phase == '0)); // R8

    if (DV > 1) begin : g_pulse
        AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld |=> !out_vld); // R10
    end
endmodule

bind vec_fir_decim vec_fir_decim_chk #(.DV(DV), .PCW(PCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .srst(srst), .in_vld(in_vld),
    .phase(phase), .out_vld(out_vld)
);

// File: tb/vec_fir_decim_bench.sv
module vec_fir_decim_bench;
    localparam int W  = 16;
    localparam int N  = 16;
    localparam int V  = 4;
    localparam int D  = 8;
    localparam int AW = 36;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          srst = 0;
    logic          in_vld = 0;
    logic [V*W-1:0] in_data = '0;
    logic          out_vld;
    logic signed [AW-1:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int stream[$];
    longint got[$];
    int fr_seen = 0;

    always #10 clk = ~clk;

    vec_fir_decim u_vec_fir_decim (
        .clk(clk), .rst_n(rst_n), .srst(srst), .in_vld(in_vld),
        .in_data(in_data), .out_vld(out_vld), .out_data(out_data)
    );

    always @(negedge clk) if (out_vld) got.push_back(longint'(out_data));

    function automatic longint hco(input int j);
        case (j)
            0: return 3;   1: return -5;  2: return 7;   3: return 2;
            4: return -1;  5: return 9;   6: return 4;   7: return -8;
            8: return 6;   9: return 1;   10: return -2; 11: return 5;
            12: return -7; 13: return 3;  14: return 8;  15: return -4;
            default: return 0;
        endcase
    endfunction

    function automatic longint ref_out(input int f);
        longint s = 0;
        for (int j = 0; j < N; j++) begin
            int i = f * D + D - 1 - j;
            if (i >= 0) s += hco(j) * longint'(stream[i]);
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int a0, input int a1, input int a2, input int a3, input bit v);
        @(negedge clk);
        in_vld  = v;
        in_data = {W'(a3), W'(a2), W'(a1), W'(a0)};
        if (v) begin
            stream.push_back(a0); stream.push_back(a1);
            stream.push_back(a2); stream.push_back(a3);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld  = 0;
            in_data = 64'h5A5A_1234_DEAD_7777;
        end
    endtask

    // Compare every output recorded since the last call against the reference.
    task automatic compare(input string req);
        int nf = stream.size() / D;
        check(got.size() == nf - fr_seen, req, got.size(), nf - fr_seen);
        for (int f = fr_seen; f < nf; f++) begin
            longint a = (f - fr_seen < got.size()) ? got[f - fr_seen] : 0;
            check(a == ref_out(f), req, a, ref_out(f));
        end
        fr_seen = nf;
        got.delete();
    endtask

    task automatic pulse_srst();
        @(negedge clk);
        in_vld = 0; srst = 1;
        @(negedge clk);
        srst = 0;
        stream.delete(); got.delete(); fr_seen = 0;
    endtask

    task automatic t_reset();   // R1
        idle(5);
        check(out_vld == 0 && got.size() == 0, "R1", out_vld, 0);
    endtask

    task automatic t_ramp();    // R2, R3
        for (int i = 0; i < 12; i++)
            drive((i*37)%200-100, (i*53)%190-95, (i*71)%170-60, (i*29)%150-75, 1);
        idle(6);
        check(got.size() == 6, "R3", got.size(), 6);
        compare("R2");
    endtask

    task automatic t_impulse(); // R5
        pulse_srst();
        drive(0, 0, 0, 1, 1);
        for (int i = 0; i < 5; i++) drive(0, 0, 0, 0, 1);
        idle(6);
        check(got.size() == 3 && got[0] == hco(4), "R5", got.size() > 0 ? got[0] : 0, hco(4));
        check(got.size() == 3 && got[1] == hco(12), "R5", got.size() > 1 ? got[1] : 0, hco(12));
        compare("R5");
    endtask

    task automatic t_gaps();    // R6
        for (int i = 0; i < 8; i++) begin
            drive(i*11-40, 300-i*7, -i*13, i*5+2, 1);
            idle(i % 3);
        end
        idle(6);
        compare("R6");
    endtask

    task automatic t_latency(); // R4, R10
        bit seen[5];
        drive(17, -4, 9, 22, 1);
        drive(-3, 8, 15, -11, 1);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            in_vld = 0;
            seen[k] = out_vld;
        end
        check(seen[1] == 0 && seen[2] == 0, "R4", seen[2], 0);
        check(seen[3] == 1, "R4", seen[3], 1);
        check(seen[4] == 0, "R10", seen[4], 0);
        idle(2);
        compare("R4");
    endtask

    task automatic t_extreme(); // R7
        for (int i = 0; i < 6; i++) drive(-32768, -32768, 32767, -32768, 1);
        idle(6);
        check(got.size() == 3 && (got[2] > 32767 || got[2] < -32768), "R7",
              got.size() > 2 ? got[2] : 0, ref_out(fr_seen + 2));
        compare("R7");
    endtask

    task automatic t_srst();    // R8
        drive(999, -999, 888, -777, 1);  // partial frame, then cleared
        pulse_srst();
        for (int i = 0; i < 4; i++) drive(i+1, 2*i-3, 40-i, -i, 1);
        idle(6);
        compare("R8");
    endtask

    task automatic t_rst_hold(); // R9
        int keep[$];
        for (int i = 0; i < 4; i++) drive(i*100+5, -i*50, 77, i-9, 1);
        idle(6);
        compare("R9");
        keep = stream;
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        stream = keep;
        for (int i = 0; i < 4; i++) drive(3-i, 12, -i*4, 6, 1);
        idle(6);
        compare("R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_ramp();
        t_impulse();
        t_gaps();
        t_latency();
        t_extreme();
        t_srst();
        t_rst_hold();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule